// File: doc/BRIEF.md
# Line-Mode PRBS Generator and Checker

This block is a per-channel test-pattern engine placed between the system-side transmit rails and the line. When the pattern enable is high, the system data is dropped. The outbound positive rail then carries an unframed maximal-length pseudo-random sequence, and the negative rail is held low, so the channel runs single-rail. The line mode sets the sequence length. With `e3_sel` low (DS3/STS-1), the generator is 15 stages long. With `e3_sel` high (E3), it is 23 stages long.

On the receive side, a self-synchronising checker shifts the incoming bits into its own register and predicts each next bit from them. It reports lock and raises a one-cycle error flag for every mismatched bit it finds while locked. The same flagged errors feed a saturating counter that software can clear with a one-cycle pulse.

The checker is a three-state machine:
- `CK_IDLE`: the block is disabled.
- `CK_HUNT`: the checker is searching for the pattern.
- `CK_LOCK`: the checker is locked.

Its transitions are:
- *enable* (`CK_IDLE`→`CK_HUNT`)
- *run complete* (`CK_HUNT`→`CK_LOCK`, after `LOCK_RUN` consecutive good predictions)
- *burst loss* (`CK_LOCK`→`CK_HUNT`, after `DROP_ERRS` errors within one `WIN_LEN`-bit window)
- *mode change* (`CK_HUNT`/`CK_LOCK`→`CK_HUNT`, when `e3_sel` toggles)
- *disable* (any state→`CK_IDLE`)

Top module: `prbs_test_unit`

## Requirements
- R1: With `pat_en` low, `line_pos` and `line_neg` equal `sys_pos` and `sys_neg` from the previous `tx_clk` edge.
- R2: With `pat_en` high, `line_neg` is 0 and `line_pos` does not depend on `sys_pos` or `sys_neg`.
- R3: With `e3_sel`=0, the output bits o(n) on `line_pos` obey o(n) = o(n-15) XOR o(n-14), and the sequence is not all zeros.
- R4: With `e3_sel`=1, the output bits obey o(n) = o(n-23) XOR o(n-18).
- R5: The generator is reloaded with all ones whenever it is disabled or the mode changes. After enable, the first outputs are therefore 14 zeros then a one in DS3 mode, and 18 zeros then a one in E3 mode.
- R6: `locked` rises only after 32 consecutive correctly predicted received bits, so it is still low 31 cycles after enable. On a clean loopback it is high within 100 cycles.
- R7: Each mispredicted bit received while locked produces a one-cycle `err_flag` pulse. A single inverted line bit produces exactly 3 pulses, because the bad bit also passes through the two feedback taps.
- R8: Eight or more errors within one 64-bit window drop `locked`. The checker relocks once clean data returns.
- R9: `err_count` adds one for each flagged error and saturates at its all-ones value.
- R10: `err_clr` sets `err_count` to 0 and takes priority over an increment in the same cycle.
- R11: With `pat_en` low, `err_flag` and `locked` stay low and `err_count` is unchanged, whatever arrives on `rx_data`.
- R12: Reset sets the line outputs, `err_flag`, `locked` and `err_count` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Transmit data-rate clock |
| rx_clk | input | 1 | Receive data-rate clock |
| rst_n | input | 1 | Synchronous active-low reset, both domains |
| pat_en | input | 1 | Enables generator and checker together |
| e3_sel | input | 1 | 1 selects the 23-stage pattern, 0 the 15-stage |
| sys_pos | input | 1 | System transmit positive rail |
| sys_neg | input | 1 | System transmit negative rail |
| rx_data | input | 1 | Received line data |
| err_clr | input | 1 | Clears the error counter (rx_clk domain) |
| line_pos | output | 1 | Outbound positive rail / pattern |
| line_neg | output | 1 | Outbound negative rail, 0 in pattern mode |
| err_flag | output | 1 | Per-bit error strobe |
| locked | output | 1 | Checker lock status |
| err_count | output | CNT_W | Saturating error count |

## Verification
The counter clear and an error increment can land on the same `rx_clk` edge. The bench provokes this by inverting one looped-back bit and raising `err_clr` in the same cycle. It then expects `err_count` to read 0 right after that edge while `err_flag` is high. Afterwards the count should rise to exactly 2 as the two tap echoes arrive. A second collision is between saturation and further increments. A narrow-counter instance receives 18 errors, and the bench judges it by `err_count` holding at 15.

// File: rtl/prbs_pkg.sv
package prbs_pkg;
    typedef enum logic [1:0] {
        CK_IDLE = 2'd0,
        CK_HUNT = 2'd1,
        CK_LOCK = 2'd2
    } chk_state_t;

    localparam int LONG_LEN  = 23;
    localparam int LONG_TA   = 22;
    localparam int LONG_TB   = 17;
    localparam int SHORT_TA  = 14;
    localparam int SHORT_TB  = 13;
endpackage

// File: rtl/prbs_tx_gen.sv
module prbs_tx_gen
    import prbs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic e3,
    input  logic sys_pos,
    input  logic sys_neg,
    output logic line_pos,
    output logic line_neg
);
    logic [LONG_LEN-1:0] sr;
    logic                mode_q;
    logic                fb;

    always_comb begin
        fb = e3 ? (sr[LONG_TA] ^ sr[LONG_TB]) : (sr[SHORT_TA] ^ sr[SHORT_TB]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr       <= '1;
            mode_q   <= 1'b0;
            line_pos <= 1'b0;
            line_neg <= 1'b0;
        end else begin
            mode_q <= e3;
            if (!en || (e3 != mode_q))
                sr <= '1;
            else
                sr <= {sr[LONG_LEN-2:0], fb};
            line_pos <= en ? fb   : sys_pos;
            line_neg <= en ? 1'b0 : sys_neg;
        end
    end

    // R2: single rail while the pattern runs
    a_r2_neg_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> !line_neg);

    // R1: transparent pass of both rails while disabled
    a_r1_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (line_pos == $past(sys_pos)) && (line_neg == $past(sys_neg)));
endmodule

// File: rtl/prbs_rx_chk.sv
module prbs_rx_chk
    import prbs_pkg::*;
#(
    parameter int LOCK_RUN  = 32,
    parameter int DROP_ERRS = 8,
    parameter int WIN_LEN   = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic e3,
    input  logic rx_data,
    output logic err_hit,
    output logic err_flag,
    output logic locked
);
    localparam int GOOD_W = $clog2(LOCK_RUN + 1);
    localparam int WIN_W  = $clog2(WIN_LEN);
    localparam int WERR_W = $clog2(DROP_ERRS + 1);

    chk_state_t          state, state_nx;
    logic [LONG_LEN-1:0] sr;
    logic                mode_q;
    logic                mode_chg;
    logic                pred;
    logic                err_bit;
    logic [GOOD_W-1:0]   good_cnt;
    logic [WIN_W-1:0]    win_cnt;
    logic [WERR_W-1:0]   win_err;

    always_comb begin
        pred     = e3 ? (sr[LONG_TA] ^ sr[LONG_TB]) : (sr[SHORT_TA] ^ sr[SHORT_TB]);
        err_bit  = rx_data ^ pred;
        mode_chg = (e3 != mode_q);
    end

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            CK_IDLE: if (en) state_nx = CK_HUNT;
            CK_HUNT: begin
                if (!en)
                    state_nx = CK_IDLE;
                else if (!mode_chg && !err_bit && (good_cnt == GOOD_W'(LOCK_RUN - 1)))
                    state_nx = CK_LOCK;
            end
            CK_LOCK: begin
                if (!en)
                    state_nx = CK_IDLE;
                else if (mode_chg)
                    state_nx = CK_HUNT;
                else if (err_bit && (win_err == WERR_W'(DROP_ERRS - 1)))
                    state_nx = CK_HUNT;
            end
            default: state_nx = CK_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= CK_IDLE;
        else        state <= state_nx;
    end

    // datapath: self-sync shift register, run and window counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr       <= '0;
            mode_q   <= 1'b0;
            good_cnt <= '0;
            win_cnt  <= '0;
            win_err  <= '0;
        end else begin
            sr     <= {sr[LONG_LEN-2:0], rx_data};
            mode_q <= e3;
            if (state == CK_HUNT && !err_bit && !mode_chg)
                good_cnt <= good_cnt + 1'b1;
            else
                good_cnt <= '0;
            if (state != CK_LOCK) begin
                win_cnt <= '0;
                win_err <= '0;
            end else begin
                win_cnt <= win_cnt + 1'b1;
                if (win_cnt == WIN_W'(WIN_LEN - 1))
                    win_err <= WERR_W'(err_bit);
                else
                    win_err <= win_err + WERR_W'(err_bit);
            end
        end
    end

    // outputs
    always_comb begin
        locked  = (state == CK_LOCK);
        err_hit = locked && en && err_bit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) err_flag <= 1'b0;
        else        err_flag <= err_hit;
    end

    // R11: disabled checker is silent
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!err_flag && !locked));

    // R6: lock is only reached from the hunt state
    a_r6_lock_from_hunt: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> ($past(state) == CK_HUNT));

    // R7: a flag only follows a locked cycle
    a_r7_flag_locked: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> $past(locked));
endmodule

// File: rtl/prbs_err_cnt.sv
module prbs_err_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (clr)
            count <= '0;
        else if (inc && (count != '1))
            count <= count + 1'b1;
    end

    // R10: clear wins
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));

    // R9: saturation holds
    a_r9_hold_max: assert property (@(posedge clk) disable iff (!rst_n)
        ((count == '1) && !clr) |=> (count == '1));

    // R9: never moves by more than one
    a_r9_step: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((count == $past(count)) || (count == $past(count) + 1'b1)));
endmodule

// File: rtl/prbs_test_unit.sv
module prbs_test_unit #(
    parameter int CNT_W     = 16,
    parameter int LOCK_RUN  = 32,
    parameter int DROP_ERRS = 8,
    parameter int WIN_LEN   = 64
) (
    input  logic             tx_clk,
    input  logic             rx_clk,
    input  logic             rst_n,
    input  logic             pat_en,
    input  logic             e3_sel,
    input  logic             sys_pos,
    input  logic             sys_neg,
    input  logic             rx_data,
    input  logic             err_clr,
    output logic             line_pos,
    output logic             line_neg,
    output logic             err_flag,
    output logic             locked,
    output logic [CNT_W-1:0] err_count
);
    logic err_hit;

    prbs_tx_gen u_gen (
        .clk      (tx_clk),
        .rst_n    (rst_n),
        .en       (pat_en),
        .e3       (e3_sel),
        .sys_pos  (sys_pos),
        .sys_neg  (sys_neg),
        .line_pos (line_pos),
        .line_neg (line_neg)
    );

    prbs_rx_chk #(
        .LOCK_RUN  (LOCK_RUN),
        .DROP_ERRS (DROP_ERRS),
        .WIN_LEN   (WIN_LEN)
    ) u_chk (
        .clk      (rx_clk),
        .rst_n    (rst_n),
        .en       (pat_en),
        .e3       (e3_sel),
        .rx_data  (rx_data),
        .err_hit  (err_hit),
        .err_flag (err_flag),
        .locked   (locked)
    );

    prbs_err_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (rx_clk),
        .rst_n (rst_n),
        .clr   (err_clr),
        .inc   (err_hit),
        .count (err_count)
    );
endmodule

// File: tb/test_prbs_test_unit.sv
`timescale 1ns/1ps
module test_prbs_test_unit;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pat_en = 1'b0, e3_sel = 1'b0, sys_pos = 1'b0, sys_neg = 1'b0;
    logic inj = 1'b0, err_clr = 1'b0;
    logic line_pos, line_neg, err_flag, locked;
    logic [15:0] err_count;
    logic line_pos_s, line_neg_s, err_flag_s, locked_s;
    logic [3:0] err_count_s;
    logic rx_data, rx_data_s;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    bit hist [0:299];

    always #2.5 clk = ~clk;

    assign rx_data   = line_pos ^ inj;
    assign rx_data_s = line_pos_s ^ inj;

    prbs_test_unit i_prbs_test_unit (
        .tx_clk(clk), .rx_clk(clk), .rst_n(rst_n), .pat_en(pat_en), .e3_sel(e3_sel),
        .sys_pos(sys_pos), .sys_neg(sys_neg), .rx_data(rx_data), .err_clr(err_clr),
        .line_pos(line_pos), .line_neg(line_neg), .err_flag(err_flag),
        .locked(locked), .err_count(err_count)
    );

    prbs_test_unit #(.CNT_W(4)) i_small (
        .tx_clk(clk), .rx_clk(clk), .rst_n(rst_n), .pat_en(pat_en), .e3_sel(e3_sel),
        .sys_pos(sys_pos), .sys_neg(sys_neg), .rx_data(rx_data_s), .err_clr(err_clr),
        .line_pos(line_pos_s), .line_neg(line_neg_s), .err_flag(err_flag_s),
        .locked(locked_s), .err_count(err_count_s)
    );

    // {en, sys_pos, sys_neg, check_pos, exp_pos, exp_neg}
    localparam logic [5:0] VEC [0:7] = '{
        6'b0_00_1_00, 6'b0_10_1_10, 6'b0_01_1_01, 6'b0_11_1_11,
        6'b1_11_0_00, 6'b1_01_0_00, 6'b1_10_0_00, 6'b0_10_1_10
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // enable, record n bits, check prefix and recurrence
    task automatic run_pattern(input bit e3, input int n, input string tag_seq);
        int zeros_exp, mism, ones, negs;
        zeros_exp = e3 ? 18 : 14;
        mism = 0; ones = 0; negs = 0;
        e3_sel = e3;
        cyc(2);
        pat_en = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            hist[i] = line_pos;
            ones += int'(line_pos);
            negs += int'(line_neg);
            sys_pos = 1'($urandom);
            sys_neg = 1'b1;
            if (i == 30) chk(locked == 1'b0, "R6 early lock", int'(locked), 0);
        end
        for (int i = 0; i <= zeros_exp; i++)
            chk(hist[i] == (i == zeros_exp), "R5 seed prefix", int'(hist[i]), int'(i == zeros_exp));
        for (int i = 23; i < n; i++) begin
            if (e3) mism += int'(hist[i] != (hist[i-23] ^ hist[i-18]));
            else    mism += int'(hist[i] != (hist[i-15] ^ hist[i-14]));
        end
        chk(mism == 0, tag_seq, mism, 0);
        chk(ones > 0, "R3 nonzero", ones, 1);
        chk(negs == 0, "R2 neg rail low", negs, 0);
        chk(locked == 1'b1, "R6 lock reached", int'(locked), 1);
    endtask

    initial begin
        int flags, c0;
        rst_n = 1'b0;
        cyc(4);
        chk(line_pos == 0 && line_neg == 0, "R12 line reset", int'(line_pos), 0);
        chk(err_flag == 0 && locked == 0, "R12 status reset", int'(locked), 0);
        chk(err_count == 0, "R12 count reset", int'(err_count), 0);
        rst_n = 1'b1;
        cyc(2);

        // R1 / R2 vector walk
        foreach (VEC[k]) begin
            pat_en = VEC[k][5]; sys_pos = VEC[k][4]; sys_neg = VEC[k][3];
            @(negedge clk);
            if (VEC[k][2]) chk(line_pos == VEC[k][1], "R1 pos pass", int'(line_pos), int'(VEC[k][1]));
            chk(line_neg == VEC[k][0], VEC[k][5] ? "R2 neg low" : "R1 neg pass",
                int'(line_neg), int'(VEC[k][0]));
        end
        pat_en = 1'b0;

        // R3 R5 R6: DS3 pattern and lock
        run_pattern(1'b0, 200, "R3 short recurrence");
        chk(err_count == 0, "R7 clean loop count", int'(err_count), 0);

        // R7 R9: one inverted bit -> three flags
        flags = 0;
        inj = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            inj = 1'b0;
            flags += int'(err_flag);
        end
        chk(flags == 3, "R7 triple flag", flags, 3);
        chk(err_count == 3, "R9 count adds", int'(err_count), 3);
        chk(locked == 1'b1, "R8 stays locked", int'(locked), 1);

        // R10: clear and increment in one cycle
        inj = 1'b1; err_clr = 1'b1;
        @(negedge clk);
        chk(err_flag == 1'b1, "R10 collision flag", int'(err_flag), 1);
        chk(err_count == 0, "R10 clear wins", int'(err_count), 0);
        inj = 1'b0; err_clr = 1'b0;
        cyc(40);
        chk(err_count == 2, "R10 echoes counted", int'(err_count), 2);
        cyc(80);

        // R8: burst drops lock, then relock
        inj = 1'b1;
        cyc(20);
        inj = 1'b0;
        @(negedge clk);
        chk(locked == 1'b0, "R8 drop", int'(locked), 0);
        chk(err_count >= 8, "R8 burst counted", int'(err_count), 8);
        cyc(100);
        chk(locked == 1'b1, "R8 relock", int'(locked), 1);

        // R4 R5: E3 pattern
        pat_en = 1'b0;
        @(negedge clk);
        chk(locked == 0 && err_flag == 0, "R11 disable clears", int'(locked), 0);
        run_pattern(1'b1, 250, "R4 long recurrence");

        // R11: disabled ignores received data
        pat_en = 1'b0;
        cyc(2);
        c0 = int'(err_count);
        flags = 0;
        for (int i = 0; i < 30; i++) begin
            inj = 1'($urandom);
            @(negedge clk);
            flags += int'(err_flag) + int'(locked);
        end
        inj = 1'b0;
        chk(flags == 0, "R11 no flag or lock", flags, 0);
        chk(int'(err_count) == c0, "R11 count frozen", int'(err_count), c0);

        // R9: saturation on narrow counter
        run_pattern(1'b0, 100, "R3 short recurrence again");
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        chk(err_count_s == 0, "R10 narrow clear", int'(err_count_s), 0);
        for (int j = 0; j < 6; j++) begin
            inj = 1'b1;
            @(negedge clk);
            inj = 1'b0;
            cyc(80);
        end
        chk(err_count == 18, "R9 wide count", int'(err_count), 18);
        chk(err_count_s == 4'hF, "R9 saturate", int'(err_count_s), 15);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cyc(20000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule